// File: doc/BRIEF.md
# Two-Channel 8-Bit SAR Converter Serial Sequencer

This block is the digital half of a two-channel successive-approximation converter. It sits between a serial host (chip select, serial clock, data in, data out) and the analog parts of the converter: a comparator, a trial DAC and a reference, all of which are outside the block. A host opens a transaction by pulling chip select low. It then clocks in a control byte whose first high bit is the start marker. The block decodes the byte and drives the channel multiplexer select. It opens and closes the track-and-hold window and runs an 8-step binary search against the comparator. The result comes back to the host serially, most significant bit first.

Two clocking modes exist. In external mode every search step is tied to a fixed serial-clock edge, so the host clock paces the conversion. In internal mode the search is paced by a divided-down conversion tick. The result is kept in a register and read out later at any serial-clock rate. A shutdown bit in the control byte puts the converter in power-down, and conversion requests are refused until a later byte clears that bit. The system clock samples every serial input; SCLK edges are detected by comparing against a registered copy of SCLK.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, dout, track_en, dac_code and pwr_down are all 0, and dout_oe is 0 while cs_n is high.
- R2: While cs_n is low and no transaction is open, DIN samples of 0 on SCLK rising edges are ignored. The first DIN sample of 1 is the start marker. The next seven rising edges capture, in order: channel bits 2, 1 and 0, clock mode (1 = internal), reference select, reference off, and shutdown. chan_sel takes the captured channel value on the 4th falling edge.
- R3: Falling edges are counted from the falling edge of the start-marker clock, which is edge 1. track_en rises on falling edge 4 and falls on falling edge 8, and chan_sel does not change while track_en is high.
- R4: In external mode, post-byte falling and rising edges are numbered from 1. The trial word 1000_0000 is set on post-byte falling edge 6. On post-byte rising edges 7 to 14 the current trial bit is kept if cmp_in is 1 and cleared if cmp_in is 0; then the next lower bit is set. dac_code ends equal to the searched value.
- R5: In external mode dout is 0 before post-byte falling edge 8. It carries result bit 7 on that edge and the next lower bit on each later falling edge through edge 15. After that it is 0 until cs_n rises, and dout is 0 in the cycle after cs_n is seen high.
- R6: In internal mode the search starts on control falling edge 8 with trial word 1000_0000 and takes one step per CONV_DIV clock cycles, eight steps in all. SCLK edges during the search do not change dout. Once the search ends, dac_code holds the result and dout shows its bit 7.
- R7: In internal mode, after the search ends, each SCLK falling edge moves dout to the next lower result bit. After bit 0 has been shown, dout is 0.
- R8: dout_oe is 1 exactly while cs_n is 0.
- R9: If cs_n rises while a search is still running, the block returns to idle, track_en drops, dac_code clears to 0, and the next transaction converts normally.
- R10: A control byte with the shutdown bit set sets pwr_down on falling edge 8 and starts no search: dac_code keeps its value and dout stays 0. pwr_down stays set until a later byte with the bit clear, which converts normally.
- R11: On falling edge 8, ref_ctl takes {reference select, reference off} from the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data, sampled on SCLK rising edges |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC trial level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the dout pad driver |
| track_en | output | 1 | Track-and-hold tracking enable |
| chan_sel | output | 3 | Analog channel select |
| dac_code | output | RES | Trial/result word driven to the DAC |
| ref_ctl | output | 2 | {reference select, reference off} |
| pwr_down | output | 1 | Power-down status |

## Verification
The bench drives the comparator from a model of the analog level against dac_code. It uses all-zero, all-one, alternating and single-bit levels, because a search that keeps a bit on the wrong comparator polarity, or steps off by one edge, gives a different word for each of them. It puts zero bits ahead of the start marker and uses unequal channel patterns to expose a decoder that takes the wrong bit as start or reverses the select order. It raises chip select in the middle of a search; a sequencer that forgets to abort would leave a partial word on dac_code. A shutdown byte checks that a block which still converted would change dac_code or drive result bits, and an SCLK edge during an internal search catches early shifting.

// File: rtl/adc_pkg.sv
package adc_pkg;

  // sequencer phases of one chip-select window
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for the start marker
    ST_CMD  = 3'd1,  // shifting in the control byte
    ST_EXT  = 3'd2,  // search paced by SCLK
    ST_INT  = 3'd3,  // search paced by the conversion tick
    ST_RD   = 3'd4,  // internal-mode result readout
    ST_HOLD = 3'd5   // nothing left to do until cs_n rises
  } seq_state_t;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    tick  = 1'b0;
    if (!run) begin
      cnt_n = '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt_n = '0;
      tick  = 1'b1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] dac,
  output logic         busy,
  output logic         done
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  dac_n;
  logic [IW-1:0] idx, idx_n;
  logic          busy_n, done_n;

  always_comb begin
    dac_n  = dac;
    idx_n  = idx;
    busy_n = busy;
    done_n = 1'b0;
    if (clr) begin
      if (busy) dac_n = '0;  // partial word is dropped
      busy_n = 1'b0;
    end else if (start) begin
      dac_n        = '0;
      dac_n[W-1]   = 1'b1;
      idx_n        = IW'(W - 1);
      busy_n       = 1'b1;
    end else if (step && busy) begin
      if (!cmp) dac_n[idx] = 1'b0;
      if (idx != '0) begin
        dac_n[idx - 1'b1] = 1'b1;
        idx_n             = idx - 1'b1;
      end else begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac  <= '0;
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      dac  <= dac_n;
      idx  <= idx_n;
      busy <= busy_n;
      done <= done_n;
    end
  end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES      = 8,
  parameter int CONV_DIV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           din,
  input  logic           cmp_in,
  output logic           dout,
  output logic           dout_oe,
  output logic           track_en,
  output logic [2:0]     chan_sel,
  output logic [RES-1:0] dac_code,
  output logic [1:0]     ref_ctl,
  output logic           pwr_down
);
  import adc_pkg::*;

  localparam int CB        = 8;                 // control byte length incl. start
  localparam int TRK_ON    = 3;                 // count before falling edge 4
  localparam int CB_LAST   = CB - 1;            // count before falling edge 8
  localparam int EXT_TRIAL = CB + RES - 3;      // count before post-byte fall 6
  localparam int OUT_LO    = CB + RES - 1;      // count before post-byte fall 8
  localparam int OUT_HI    = CB + 2 * RES - 2;  // count before post-byte fall 15
  localparam int CNT_MAX   = OUT_HI + 1;
  localparam int FW        = $clog2(CNT_MAX + 1);
  localparam int IW        = $clog2(RES);
  localparam int OW        = $clog2(RES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  seq_state_t    st, st_n;
  logic [FW-1:0] fcnt, fcnt_n;
  logic [6:0]    shreg, shreg_n;
  logic [OW-1:0] ocnt, ocnt_n;
  logic [2:0]    chan, chan_n;
  logic [1:0]    refc, refc_n;
  logic          trk, trk_n, pd, pd_n, dout_r, dout_n, sclk_q;
  logic          rise, fall, sar_start, sar_step, sar_clr;
  logic          tick, busy, done;
  logic [IW-1:0] oidx, ridx;
  logic [RES-1:0] dac;

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;
  assign oidx = IW'(OUT_HI) - fcnt[IW-1:0];
  assign ridx = IW'(RES - 1) - ocnt[IW-1:0];

  adc_conv_timer #(.DIV(CONV_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_s), .run(st == ST_INT), .tick(tick)
  );

  adc_sar_core #(.W(RES)) u_sar (
    .clk(clk), .rst_n(rst_s), .clr(sar_clr), .start(sar_start),
    .step(sar_step), .cmp(cmp_in), .dac(dac), .busy(busy), .done(done)
  );

  always_comb begin
    st_n      = st;
    fcnt_n    = fcnt;
    shreg_n   = shreg;
    ocnt_n    = ocnt;
    chan_n    = chan;
    refc_n    = refc;
    trk_n     = trk;
    pd_n      = pd;
    dout_n    = dout_r;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    sar_clr   = 1'b0;
    if (cs_n) begin
      st_n    = ST_IDLE;
      trk_n   = 1'b0;
      dout_n  = 1'b0;
      sar_clr = 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rise && din) begin
            st_n   = ST_CMD;
            fcnt_n = '0;
          end
        end
        ST_CMD: begin
          if (rise) shreg_n = {shreg[5:0], din};
          if (fall) begin
            fcnt_n = fcnt + 1'b1;
            if (fcnt == FW'(TRK_ON)) begin
              trk_n  = 1'b1;
              chan_n = shreg[2:0];
            end
            if (fcnt == FW'(CB_LAST)) begin
              trk_n  = 1'b0;
              chan_n = shreg[6:4];
              refc_n = shreg[2:1];
              pd_n   = shreg[0];
              if (shreg[0]) begin
                st_n = ST_HOLD;
              end else if (shreg[3]) begin
                st_n      = ST_INT;
                sar_start = 1'b1;
              end else begin
                st_n = ST_EXT;
              end
            end
          end
        end
        ST_EXT: begin
          if (fall) begin
            if (fcnt != FW'(CNT_MAX)) fcnt_n = fcnt + 1'b1;
            if (fcnt == FW'(EXT_TRIAL)) sar_start = 1'b1;
            if (fcnt >= FW'(OUT_LO) && fcnt <= FW'(OUT_HI)) dout_n = dac[oidx];
            else                                             dout_n = 1'b0;
          end
          if (rise && busy) sar_step = 1'b1;
        end
        ST_INT: begin
          sar_step = tick;
          if (done) begin
            st_n   = ST_RD;
            dout_n = dac[RES-1];
            ocnt_n = OW'(1);
          end
        end
        ST_RD: begin
          if (fall) begin
            if (ocnt < OW'(RES)) begin
              dout_n = dac[ridx];
              ocnt_n = ocnt + 1'b1;
            end else begin
              dout_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st     <= ST_IDLE;
      fcnt   <= '0;
      shreg  <= '0;
      ocnt   <= '0;
      chan   <= '0;
      refc   <= '0;
      trk    <= 1'b0;
      pd     <= 1'b0;
      dout_r <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      st     <= st_n;
      fcnt   <= fcnt_n;
      shreg  <= shreg_n;
      ocnt   <= ocnt_n;
      chan   <= chan_n;
      refc   <= refc_n;
      trk    <= trk_n;
      pd     <= pd_n;
      dout_r <= dout_n;
      sclk_q <= sclk;
    end
  end

  assign dout     = dout_r;
  assign dout_oe  = ~cs_n;
  assign track_en = trk;
  assign chan_sel = chan;
  assign dac_code = dac;
  assign ref_ctl  = refc;
  assign pwr_down = pd;

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int RES = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           track_en,
  input logic           dout,
  input logic           pwr_down,
  input logic [2:0]     chan_sel,
  input logic [RES-1:0] dac_code
);

  AST_CS_HIGH_DROPS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !track_en);  // R9

  AST_CS_HIGH_ZEROES_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout);  // R5

  AST_CHAN_STABLE_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && $past(track_en)) |-> $stable(chan_sel));  // R3

  AST_PWRDN_NO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> !track_en);  // R10

  AST_PWRDN_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $stable(dac_code));  // R10

endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .track_en(track_en), .dout(dout),
  .pwr_down(pwr_down), .chan_sel(chan_sel), .dac_code(dac_code)
);

// File: tb/sim_adc_sar_seq.sv
module sim_adc_sar_seq;
  localparam int RES = 8;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, din, cmp_in;
  logic dout, dout_oe, track_en, pwr_down;
  logic [2:0] chan_sel;
  logic [1:0] ref_ctl;
  logic [RES-1:0] dac_code;
  logic [RES-1:0] vin;

  int checks = 0;
  int fails  = 0;
  bit fin    = 1'b0;

  logic  exp_q[$];
  string tag_q[$];
  event  smp;

  always #5 clk = ~clk;

  // external comparator model: 1 when the level is at or above the trial word
  assign cmp_in = (vin >= dac_code);

  adc_sar_seq #(.RES(RES), .CONV_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe), .track_en(track_en),
    .chan_sel(chan_sel), .dac_code(dac_code), .ref_ctl(ref_ctl),
    .pwr_down(pwr_down)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected serial bits and compares them with dout
  always @(smp) begin
    while (exp_q.size() > 0) begin
      logic  b;
      string t;
      b = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(dout), int'(b));
    end
  end

  task automatic expect_bit(input logic b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    ->smp;
    #0;
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic sclk_cyc(input logic b);
    din  = b;
    sclk = 1'b1;
    half();
    sclk = 1'b0;
    half();
  endtask

  task automatic send_byte(input logic [2:0] ch, input logic im, input logic [1:0] rf,
                           input logic sd);
    logic [7:0] bits;
    bits = {1'b1, ch, im, rf, sd};
    for (int i = 7; i >= 0; i--) begin
      sclk_cyc(bits[i]);
      if (8 - i == 3) chk("R3 track before edge 4", int'(track_en), 0);
      if (8 - i == 4) begin
        chk("R3 track at edge 4", int'(track_en), 1);
        chk("R2 chan_sel", int'(chan_sel), int'(ch));
      end
      if (8 - i == 8) begin
        chk("R3 track off at edge 8", int'(track_en), 0);
        chk("R11 ref_ctl", int'(ref_ctl), int'(rf));
        chk("R10 pwr_down flag", int'(pwr_down), int'(sd));
      end
    end
  endtask

  task automatic xfer_ext(input logic [7:0] v, input logic [2:0] ch, input logic [1:0] rf,
                          input logic sd, input int lead, input int exp_dac);
    vin  = v;
    cs_n = 1'b0;
    half();
    chk("R8 oe low cs", int'(dout_oe), 1);
    for (int i = 0; i < lead; i++) sclk_cyc(1'b0);
    send_byte(ch, 1'b0, rf, sd);
    for (int p = 1; p <= 17; p++) begin
      sclk_cyc(1'b0);
      if (sd)                  expect_bit(1'b0, "R10 dout silent");
      else if (p >= 8 && p <= 15) expect_bit(v[15 - p], "R5 result bit");
      else                     expect_bit(1'b0, "R5 zero fill");
    end
    chk(sd ? "R10 dac kept" : "R4 search result", int'(dac_code), exp_dac);
    cs_n = 1'b1;
    half();
    chk("R8 oe high cs", int'(dout_oe), 0);
    chk("R5 dout after cs", int'(dout), 0);
  endtask

  task automatic xfer_int(input logic [7:0] v, input logic [2:0] ch);
    vin  = v;
    cs_n = 1'b0;
    half();
    send_byte(ch, 1'b1, 2'b10, 1'b0);
    sclk_cyc(1'b0);
    expect_bit(1'b0, "R6 no shift while converting");
    repeat (8 * DIV + 10) @(negedge clk);
    chk("R6 msb after search", int'(dout), int'(v[7]));
    chk("R6 result", int'(dac_code), int'(v));
    for (int q = 1; q <= 10; q++) begin
      sclk_cyc(1'b0);
      if (q < 8) expect_bit(v[7 - q], "R7 readout bit");
      else       expect_bit(1'b0, "R7 zero fill");
    end
    cs_n = 1'b1;
    half();
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    din   = 1'b0;
    vin   = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 dout", int'(dout), 0);
    chk("R1 dout_oe", int'(dout_oe), 0);
    chk("R1 track_en", int'(track_en), 0);
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 pwr_down", int'(pwr_down), 0);

    xfer_ext(8'hA5, 3'b101, 2'b01, 1'b0, 2, 'hA5);
    xfer_ext(8'h00, 3'b010, 2'b10, 1'b0, 0, 'h00);
    xfer_ext(8'hFF, 3'b001, 2'b11, 1'b0, 3, 'hFF);
    xfer_int(8'h96, 3'b110);
    xfer_int(8'h01, 3'b011);

    // R9: chip select raised in the middle of an external search
    vin  = 8'h5A;
    cs_n = 1'b0;
    half();
    send_byte(3'b100, 1'b0, 2'b00, 1'b0);
    for (int p = 1; p <= 10; p++) sclk_cyc(1'b0);
    cs_n = 1'b1;
    half();
    chk("R9 dac cleared", int'(dac_code), 0);
    chk("R9 track low", int'(track_en), 0);
    xfer_ext(8'h3C, 3'b111, 2'b00, 1'b0, 1, 'h3C);

    // R10: shutdown byte refuses the conversion, next clear byte converts
    xfer_ext(8'hC3, 3'b000, 2'b01, 1'b1, 0, 'h3C);
    chk("R10 pwr_down held", int'(pwr_down), 1);
    xfer_ext(8'h81, 3'b010, 2'b00, 1'b0, 0, 'h81);
    chk("R10 pwr_down cleared", int'(pwr_down), 0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule